// File: doc/BRIEF.md
# Preemptive Priority Interrupt Controller

This block sits between a group of interrupt sources and a single processor. The sources are level-sensitive hardware request lines plus a few software-settable flags. Each source has its own 4-bit priority, and the controller keeps a current-priority level for the handler that is now running. It raises the processor interrupt only when a pending source has a priority strictly above that level. The number of the winning source is captured as the vector at the moment the interrupt goes high.

The handler first reads the acknowledge register. That read returns the captured vector, saves the running level on an internal last-in-first-out stack, and raises the current level to the priority of the acknowledged source. The handler then clears its source. Finally it writes the end-of-interrupt register, which pulls the saved level back off the stack. After that pull the controller does not search for the interrupted source again: only sources above the restored level can interrupt.

Register access uses a valid/ready request channel. `bus_ready` is held high, so the controller never applies back-pressure and every request with `bus_valid` high is taken on that clock edge. Read data comes back one cycle later on `rd_valid`/`rd_data`. That return path has no ready signal, so the requester must always be able to take it.

Top module: `prio_intc`

## Requirements
- R1: `irq_o` goes high only when some pending source with nonzero priority has a priority strictly greater than the current priority; pending sources at or below the current priority never raise it.
- R2: A source whose priority is 0 is never serviced, even while it is pending.
- R3: The winner is the pending source with the highest priority; when sources tie, the lowest source number wins. Hardware line i is source i, and software flag j is source NUM_HW+j.
- R4: The vector (winner's source number) is captured when `irq_o` rises and is held unchanged until the next rise, even if a different source becomes the winner in between.
- R5: A read of address 0x23 returns the held vector, pushes the current priority onto the stack, loads the held source's priority as the current priority, and forces `irq_o` low on the next cycle.
- R6: A write of any data to address 0x24 pops the stack into the current priority; a source still pending at the restored level does not raise `irq_o`.
- R7: Writing a mask to 0x20 sets the software flags whose bits are 1, and writing a mask to 0x21 clears them. A read of either address returns the flags, with bit j being flag j.
- R8: The stack is 15 deep. A push when full is dropped and sets status bit 0; a pop when empty is dropped, leaves the current priority unchanged and sets status bit 1. Status is read at 0x25, and any write to 0x25 clears it.
- R9: After reset, `irq_o` is low, the current priority is 0, the stack is empty, the status and software flags are 0, and every source priority is 0.
- R10: `bus_ready` is always 1. `irq_o` responds to source changes one clock after them and to register writes two clocks after the write is accepted. Read data appears with `rd_valid` one clock after the request is accepted.
- R11: Address 0x22 reads and writes the current priority in bits 3:0. Addresses 0..NUM_HW+NUM_SW-1 read and write the per-source priorities in bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_irq | input | NUM_HW | Level hardware request lines |
| bus_valid | input | 1 | Register request valid |
| bus_ready | output | 1 | Register request ready (always 1) |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Register address |
| bus_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after the read |
| rd_data | output | DATA_W | Read data |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A change on a hardware line affects `irq_o` at the next clock edge. A register write affects it at the second edge, because the write first updates a register and the interrupt is then recomputed from it. A read's data is due one edge after the request. The bench applies its inputs on falling edges and runs a behavioural model on each rising edge. It compares `irq_o`, `rd_valid` and `rd_data` on the following falling edge, so every expected value is taken in the exact cycle it becomes due. Directed checks wait exactly one or two cycles after a stimulus before they test `irq_o`.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int PRIO_W = 4;
  localparam int ADDR_W = 6;
  typedef logic [PRIO_W-1:0] prio_t;

  localparam logic [ADDR_W-1:0] ADR_SWSET  = 6'h20;
  localparam logic [ADDR_W-1:0] ADR_SWCLR  = 6'h21;
  localparam logic [ADDR_W-1:0] ADR_CURPRI = 6'h22;
  localparam logic [ADDR_W-1:0] ADR_ACK    = 6'h23;
  localparam logic [ADDR_W-1:0] ADR_EOI    = 6'h24;
  localparam logic [ADDR_W-1:0] ADR_STAT   = 6'h25;
endpackage

// File: rtl/pic_arbiter.sv
module pic_arbiter
  import pic_pkg::*;
#(
  parameter int N     = 12,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]        pend,
  input  logic [N*PRIO_W-1:0] prio_flat,
  output logic [IDX_W-1:0]    win_idx,
  output prio_t               win_prio,
  output logic                win_valid
);
  prio_t       pr   [N];
  logic [N-1:0] elig;

  for (genvar g = 0; g < N; g++) begin : g_src
    assign pr[g]   = prio_flat[g*PRIO_W +: PRIO_W];
    assign elig[g] = pend[g] && (pr[g] != '0);
  end

  // Strict compare while scanning upward: lowest index keeps ties.
  always_comb begin
    win_idx  = '0;
    win_prio = '0;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (pr[i] > win_prio)) begin
        win_idx  = IDX_W'(i);
        win_prio = pr[i];
      end
    end
  end

  assign win_valid = (win_prio != '0);
endmodule

// File: rtl/pic_lifo.sv
module pic_lifo
  import pic_pkg::*;
#(
  parameter int DEPTH = 15,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  prio_t            din,
  output prio_t            top,
  output logic             full,
  output logic             empty,
  output logic [CNT_W-1:0] count
);
  prio_t            mem [DEPTH];
  logic [CNT_W-1:0] cnt_q;

  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);
  assign count = cnt_q;
  assign top   = empty ? '0 : mem[cnt_q - CNT_W'(1)];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (push && !full) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end else if (pop && !empty) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) mem[cnt_q] <= din;
  end
endmodule

// File: rtl/pic_regs.sv
module pic_regs
  import pic_pkg::*;
#(
  parameter int NUM_HW = 8,
  parameter int NUM_SW = 4,
  parameter int DATA_W = 16,
  parameter int NUM_SRC = NUM_HW + NUM_SW
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  input  logic                      ovf_set,
  input  logic                      unf_set,
  output logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  output logic [NUM_SW-1:0]         sw_flags,
  output logic                      ovf,
  output logic                      unf
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_prio
    prio_t p_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               p_q <= '0;
      else if (wr_en && addr == ADDR_W'(g))     p_q <= wdata[PRIO_W-1:0];
    end
    assign prio_flat[g*PRIO_W +: PRIO_W] = p_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_flags <= '0;
    end else if (wr_en && addr == ADR_SWSET) begin
      sw_flags <= sw_flags | wdata[NUM_SW-1:0];
    end else if (wr_en && addr == ADR_SWCLR) begin
      sw_flags <= sw_flags & ~wdata[NUM_SW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf <= 1'b0;
      unf <= 1'b0;
    end else begin
      if (wr_en && addr == ADR_STAT) begin
        ovf <= 1'b0;
        unf <= 1'b0;
      end
      if (ovf_set) ovf <= 1'b1;
      if (unf_set) unf <= 1'b1;
    end
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import pic_pkg::*;
#(
  parameter int NUM_HW = 8,
  parameter int NUM_SW = 4,
  parameter int DEPTH  = 15,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_HW-1:0] hw_irq,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_o
);
  localparam int NUM_SRC = NUM_HW + NUM_SW;
  localparam int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int CNT_W   = $clog2(DEPTH + 1);

  logic rd_fire, wr_fire, ack_fire, eoi_fire, cur_wr;
  assign bus_ready = 1'b1;
  assign rd_fire   = bus_valid && !bus_we;
  assign wr_fire   = bus_valid && bus_we;
  assign ack_fire  = rd_fire && (bus_addr == ADR_ACK);
  assign eoi_fire  = wr_fire && (bus_addr == ADR_EOI);
  assign cur_wr    = wr_fire && (bus_addr == ADR_CURPRI);

  logic [NUM_SRC*PRIO_W-1:0] prio_flat;
  logic [NUM_SW-1:0]         sw_flags;
  logic                      ovf, unf;
  logic                      lifo_full, lifo_empty;
  prio_t                     lifo_top;
  logic [CNT_W-1:0]          lifo_cnt;
  prio_t                     cur_prio;

  pic_regs #(.NUM_HW(NUM_HW), .NUM_SW(NUM_SW), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_fire), .addr(bus_addr),
    .wdata(bus_wdata), .ovf_set(ack_fire && lifo_full),
    .unf_set(eoi_fire && lifo_empty), .prio_flat(prio_flat),
    .sw_flags(sw_flags), .ovf(ovf), .unf(unf)
  );

  pic_lifo #(.DEPTH(DEPTH)) u_lifo (
    .clk(clk), .rst_n(rst_n), .push(ack_fire), .pop(eoi_fire),
    .din(cur_prio), .top(lifo_top), .full(lifo_full),
    .empty(lifo_empty), .count(lifo_cnt)
  );

  logic [IDX_W-1:0] win_idx;
  prio_t            win_prio;
  logic             win_valid;

  pic_arbiter #(.N(NUM_SRC), .IDX_W(IDX_W)) u_arb (
    .pend({sw_flags, hw_irq}), .prio_flat(prio_flat),
    .win_idx(win_idx), .win_prio(win_prio), .win_valid(win_valid)
  );

  logic             irq_q, irq_d;
  logic [IDX_W-1:0] vec_q;
  prio_t            vec_prio_q;

  assign irq_d = win_valid && (win_prio > cur_prio) && !ack_fire;
  assign irq_o = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q      <= 1'b0;
      vec_q      <= '0;
      vec_prio_q <= '0;
    end else begin
      irq_q <= irq_d;
      if (irq_d && !irq_q) begin
        vec_q      <= win_idx;
        vec_prio_q <= win_prio;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cur_prio <= '0;
    else if (ack_fire)                cur_prio <= vec_prio_q;
    else if (eoi_fire && !lifo_empty) cur_prio <= lifo_top;
    else if (cur_wr)                  cur_prio <= bus_wdata[PRIO_W-1:0];
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (bus_addr == ADDR_W'(i)) rd_mux = DATA_W'(prio_flat[i*PRIO_W +: PRIO_W]);
    end
    case (bus_addr)
      ADR_SWSET, ADR_SWCLR: rd_mux = DATA_W'(sw_flags);
      ADR_CURPRI:           rd_mux = DATA_W'(cur_prio);
      ADR_ACK:              rd_mux = DATA_W'(vec_q);
      ADR_STAT:             rd_mux = DATA_W'({unf, ovf});
      default:              ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_fire;
      if (rd_fire) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/pic_checker.sv
module pic_checker
  import pic_pkg::*;
#(
  parameter int DEPTH = 15,
  parameter int CNT_W = 4,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_o,
  input logic             ack_fire,
  input logic             eoi_fire,
  input prio_t            cur_prio,
  input prio_t            vec_prio,
  input logic [IDX_W-1:0] vec_q,
  input logic [CNT_W-1:0] lifo_cnt,
  input prio_t            lifo_top
);
  a_r1_rise_outranks: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> (vec_prio > $past(cur_prio)));

  a_r2_no_zero_prio: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (vec_prio != '0));

  a_r4_vec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && $past(irq_o)) |-> $stable(vec_q));

  a_r5_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> !irq_o);

  a_r5_ack_push: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && lifo_cnt < CNT_W'(DEPTH)) |=>
      (lifo_cnt == $past(lifo_cnt) + CNT_W'(1)) && (lifo_top == $past(cur_prio)));

  a_r6_pop_restore: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_fire && lifo_cnt != '0) |=> (cur_prio == $past(lifo_top)));

  a_r8_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && lifo_cnt == CNT_W'(DEPTH)) |=> $stable(lifo_cnt));

  a_r8_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_fire && lifo_cnt == '0) |=> ($stable(cur_prio) && lifo_cnt == '0));
endmodule

bind prio_intc pic_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .ack_fire(ack_fire),
  .eoi_fire(eoi_fire), .cur_prio(cur_prio), .vec_prio(vec_prio_q),
  .vec_q(vec_q), .lifo_cnt(lifo_cnt), .lifo_top(lifo_top)
);

// File: tb/prio_intc_tb.sv
`timescale 1ns/1ps
module prio_intc_tb;
  localparam int NHW = 8;
  localparam int NSW = 4;
  localparam int NS  = NHW + NSW;
  localparam int DW  = 16;
  localparam int DEP = 15;

  logic clk = 0, rst_n = 0;
  logic [NHW-1:0] hw_irq = '0;
  logic bus_valid = 0, bus_we = 0;
  logic [5:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic bus_ready, rd_valid, irq_o;
  logic [DW-1:0] rd_data;

  always #10 clk = ~clk;

  prio_intc #(.NUM_HW(NHW), .NUM_SW(NSW), .DEPTH(DEP), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .hw_irq(hw_irq), .bus_valid(bus_valid),
    .bus_ready(bus_ready), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_valid(rd_valid), .rd_data(rd_data), .irq_o(irq_o)
  );

  int n_chk = 0, n_bad = 0;
  string phase = "R9";

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_prio[NS];
  bit m_sw[NSW];
  int m_cur, m_vec, m_vprio, m_rdd;
  int m_stack[$];
  bit m_irq, m_ovf, m_unf, m_rdv;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_prio[i]) m_prio[i] = 0;
      foreach (m_sw[i]) m_sw[i] = 0;
      m_cur = 0; m_vec = 0; m_vprio = 0; m_rdd = 0;
      m_stack.delete();
      m_irq = 0; m_ovf = 0; m_unf = 0; m_rdv = 0;
    end else begin
      int best, bp, a, d, newcur;
      bit ack, eoi, irqn;
      best = 0; bp = 0;
      for (int i = 0; i < NS; i++) begin
        bit p;
        p = (i < NHW) ? hw_irq[i] : m_sw[i-NHW];
        if (p && m_prio[i] > bp) begin best = i; bp = m_prio[i]; end
      end
      a = int'(bus_addr); d = int'(bus_wdata);
      ack = bus_valid && !bus_we && a == 'h23;
      eoi = bus_valid && bus_we && a == 'h24;
      irqn = (bp > 0) && (bp > m_cur) && !ack;
      m_rdv = bus_valid && !bus_we;
      if (m_rdv) begin
        if (a < NS) m_rdd = m_prio[a];
        else if (a == 'h20 || a == 'h21) begin
          m_rdd = 0;
          for (int j = 0; j < NSW; j++) if (m_sw[j]) m_rdd += (1 << j);
        end
        else if (a == 'h22) m_rdd = m_cur;
        else if (a == 'h23) m_rdd = m_vec;
        else if (a == 'h25) m_rdd = m_ovf + 2*m_unf;
        else m_rdd = 0;
      end
      newcur = m_cur;
      if (ack) begin
        if (m_stack.size() < DEP) m_stack.push_back(m_cur); else m_ovf = 1;
        newcur = m_vprio;
      end
      if (eoi) begin
        if (m_stack.size() == 0) m_unf = 1; else newcur = m_stack.pop_back();
      end
      if (bus_valid && bus_we) begin
        if (a < NS) m_prio[a] = d & 15;
        if (a == 'h22) newcur = d & 15;
        if (a == 'h20) for (int j = 0; j < NSW; j++) if (d[j]) m_sw[j] = 1;
        if (a == 'h21) for (int j = 0; j < NSW; j++) if (d[j]) m_sw[j] = 0;
        if (a == 'h25) begin m_ovf = 0; m_unf = 0; end
      end
      m_cur = newcur;
      if (irqn && !m_irq) begin m_vec = best; m_vprio = bp; end
      m_irq = irqn;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check({phase, " irq"}, int'(irq_o), int'(m_irq));
      check({phase, " rd_valid R10"}, int'(rd_valid), int'(m_rdv));
      check("R10 bus_ready", int'(bus_ready), 1);
      if (m_rdv) check({phase, " rd_data"}, int'(rd_data), m_rdd);
    end
  end

  task automatic wr(input int a, input int d);
    bus_valid = 1; bus_we = 1; bus_addr = 6'(a); bus_wdata = DW'(d);
    @(negedge clk);
    bus_valid = 0; bus_we = 0;
  endtask

  task automatic rd(input int a, output int d);
    bus_valid = 1; bus_we = 0; bus_addr = 6'(a);
    @(negedge clk);
    bus_valid = 0;
    d = int'(rd_data);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #(150000 * 20);
    n_bad++;
    $display("FAIL R10 watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int v;
    idle(3);
    rst_n = 1;
    idle(1);
    // R9 reset state
    check("R9 irq", int'(irq_o), 0);
    rd('h22, v); check("R9 cur prio", v, 0);
    rd('h25, v); check("R9 status", v, 0);
    rd('h20, v); check("R9 sw flags", v, 0);
    rd(5, v);    check("R9 source prio", v, 0);

    // R3 tie: sources 2 and 6 at priority 5
    phase = "R3";
    wr(2, 5); wr(6, 5);
    hw_irq = 8'b0100_0100;
    idle(2);
    check("R1 irq raised", int'(irq_o), 1);
    rd('h23, v); check("R3 tie lowest index", v, 2);
    idle(1);
    check("R5 irq dropped after ack", int'(irq_o), 0);
    rd('h22, v); check("R5 cur loaded", v, 5);
    rd(2, v);    check("R11 prio readback", v, 5);

    // Preemption and end-of-interrupt
    phase = "R6";
    wr(4, 9);
    hw_irq[4] = 1;
    idle(1);
    check("R10 irq one cycle after line", int'(irq_o), 1);
    rd('h23, v); check("R5 ack vector", v, 4);
    rd('h22, v); check("R5 cur raised", v, 9);
    hw_irq[4] = 0;
    wr('h24, 0);
    idle(2);
    check("R6 no re-search at restored level", int'(irq_o), 0);
    rd('h22, v); check("R6 cur restored", v, 5);

    // Priority zero
    phase = "R2";
    hw_irq = '0;
    wr('h24, 0);
    rd('h22, v); check("R6 cur restored to 0", v, 0);
    wr(7, 0);
    hw_irq[7] = 1;
    idle(3);
    check("R2 zero prio ignored", int'(irq_o), 0);
    hw_irq = '0;

    // Vector held while irq stays high
    phase = "R4";
    wr(1, 3); wr(3, 8);
    hw_irq[1] = 1;
    idle(2);
    hw_irq[3] = 1;
    idle(2);
    check("R4 irq held", int'(irq_o), 1);
    rd('h23, v); check("R4 vector held", v, 1);
    idle(2);
    check("R1 higher source raises", int'(irq_o), 1);
    rd('h23, v); check("R4 new vector", v, 3);
    rd('h22, v); check("R5 cur 8", v, 8);
    hw_irq = '0;
    wr('h24, 0); wr('h24, 0);
    rd('h22, v); check("R6 cur back to 0", v, 0);

    // Software sources
    phase = "R7";
    wr(NHW + 1, 7);
    wr('h20, 2);
    idle(2);
    check("R7 sw irq", int'(irq_o), 1);
    rd('h20, v); check("R7 sw flags set", v, 2);
    rd('h23, v); check("R7 sw vector", v, NHW + 1);
    wr('h21, 2);
    wr('h24, 0);
    rd('h21, v); check("R7 sw flags cleared", v, 0);

    // Current priority register
    phase = "R11";
    wr('h22, 6);
    wr('h20, 2);
    idle(2);
    check("R11 irq above cur", int'(irq_o), 1);
    wr('h22, 7);
    idle(2);
    check("R1 equal prio no irq", int'(irq_o), 0);
    rd('h22, v); check("R11 cur readback", v, 7);
    wr('h21, 2);
    wr('h22, 0);

    // Stack overflow and underflow
    phase = "R8";
    for (int i = 0; i < DEP + 1; i++) rd('h23, v);
    rd('h25, v); check("R8 overflow flag", v, 1);
    for (int i = 0; i < DEP; i++) wr('h24, 0);
    rd('h25, v); check("R8 no underflow yet", v, 1);
    wr('h24, 0);
    rd('h25, v); check("R8 underflow flag", v, 3);
    wr('h25, 0);
    rd('h25, v); check("R8 status cleared", v, 0);

    // Mixed traffic against the model
    phase = "R1 mixed";
    wr('h22, 0);
    for (int i = 0; i < 600; i++) begin
      int op;
      hw_irq = NHW'($urandom);
      op = $urandom_range(0, 9);
      case (op)
        0: wr($urandom_range(0, NS - 1), $urandom_range(0, 15));
        1: rd('h23, v);
        2: wr('h24, 0);
        3: wr('h20, $urandom_range(0, 15));
        4: wr('h21, $urandom_range(0, 15));
        5: rd($urandom_range(0, 'h25), v);
        6: wr('h22, $urandom_range(0, 15));
        default: idle(1);
      endcase
    end
    idle(2);
    summary();
    $finish;
  end
endmodule